// File: doc/BRIEF.md
# Memory-Mapped Parallel Port Overlay

This block sits on the memory bus of a Z80-style host and places a 24-bit parallel I/O port inside a 4-byte window. The window lies in a mirrored image of the host ROM. Software reaches the port with ordinary memory reads and writes, so a BASIC interpreter can drive it with PEEK and POKE, and no I/O instructions are needed. The default window starts at decimal 49148.

While a memory-request cycle addresses the window, the block asserts an override output. That output forces the host ROM chip-select high, so the ROM stays off the bus. The window holds three 8-bit ports (A, B and C) and one control register. The control register can only be written. Only the plain input/output mode is provided, and each port sets its direction independently. Port C sets direction separately for each nibble.

Writes are taken on the rising clock edge while the memory-request and write strobes are both low. Reads are combinational: the block drives the read data and its enable for as long as the memory-request and read strobes are low.

Top module: `memmap_pio`

## Requirements
- R1: `rom_off` is 1 only when `mreq_n` is 0 and `bus_addr` is one of BASE..BASE+3 (49148..49151 by default). At every other address, and whenever `mreq_n` is 1, it is 0.
- R2: When `mreq_n` is 1, no write has any effect and `bus_rdata_oe` stays 0.
- R3: After reset all 24 bits are inputs (`pio_oe` is all zero) and every output latch is zero.
- R4: A control write at BASE+3 with bit 7 set sets the directions, where 1 means input. Bit 4 sets port A (`pio_*[7:0]`), bit 1 sets port B (`[15:8]`), bit 3 sets port C upper (`[23:20]`) and bit 0 sets port C lower (`[19:16]`). Writing 128 makes all 24 bits outputs.
- R5: Every control write with bit 7 set clears all 24 output latches to zero.
- R6: A control write with bit 7 clear changes neither the directions nor the latches.
- R7: A write at BASE+0, BASE+1 or BASE+2 loads the latch of port A, B or C. `pio_out` always shows the latches, and `pio_oe` is 1 for the bits that are outputs. For example, writing 255 to port A after 128 to control drives `pio_out[7:0]` to 8'hFF.
- R8: A read of a port drives `bus_rdata_oe` to 1. The data holds the `pio_in` value for each input bit and the latch value for each output bit.
- R9: A read at BASE+3 leaves `bus_rdata_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid while bus_rdata_oe is 1 |
| bus_rdata_oe | output | 1 | Drive enable for the host data bus |
| mreq_n | input | 1 | Memory-request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_off | output | 1 | 1: force the host ROM chip-select high; 0: release it |
| pio_in | input | 24 | Pin levels; port C at [23:16], port B at [15:8], port A at [7:0] |
| pio_out | output | 24 | Output latches, same layout |
| pio_oe | output | 24 | Per-bit output enable, same layout |

## Verification
A wrong direction mask appears on `pio_oe` in the cycle after the control write. Read-back then mixes pins and latches in the wrong bits. A latch that fails to clear or load shows on `pio_out` one clock after the write. Decode faults show immediately, because `rom_off` and `bus_rdata_oe` are combinational and are swept over every address. Ignored control writes are checked through `pio_oe` and `pio_out` before the next access.

// File: rtl/pio_pkg.sv
// Shared constants and the control-byte decode for the parallel port overlay.
// Assumes three 8-bit ports and one control slot in a 4-byte window.
package pio_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int PIO_W     = PORT_W * NUM_PORTS;

    typedef enum logic [1:0] {
        SLOT_A    = 2'd0,
        SLOT_B    = 2'd1,
        SLOT_C    = 2'd2,
        SLOT_CTRL = 2'd3
    } slot_e;

    // Expand a mode-set byte into a per-bit input mask (1 = input).
    function automatic logic [PIO_W-1:0] ctrl_to_inmask(input logic [7:0] c);
        return {{4{c[3]}}, {4{c[0]}}, {8{c[1]}}, {8{c[4]}}};
    endfunction
endpackage

// File: rtl/pio_decode.sv
// Address decoder: finds the 4-byte window during memory-request cycles,
// names the slot and produces per-port write strobes and a read enable.
// Assumes BASE_ADDR is 4-byte aligned.
module pio_decode
    import pio_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hBFFC
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 mreq_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output logic                 hit,
    output slot_e                slot,
    output logic [NUM_PORTS-1:0] wr_port,
    output logic                 wr_ctrl,
    output logic                 rd_en
);
    // Window match on the upper address bits during a memory cycle.
    always_comb begin
        hit     = !mreq_n && (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
        slot    = slot_e'(addr[1:0]);
        wr_ctrl = hit && !wr_n && (slot == SLOT_CTRL);
        rd_en   = hit && !rd_n;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PORTS; gi++) begin : g_wr
            // Write strobe for port gi.
            assign wr_port[gi] = hit && !wr_n && (addr[1:0] == 2'(gi));
        end
    endgenerate
endmodule

// File: rtl/pio_ctrl.sv
// Control register: holds the direction mask; acts only on bytes with
// bit 7 set and then pulses mode_set to clear the output latches.
module pio_ctrl
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic [PIO_W-1:0] in_mask,
    output logic             mode_set
);
    // A mode-set is a control write whose top bit is 1.
    assign mode_set = wr_en && wdata[7];

    // Direction mask register; resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_mask <= '1;
        else if (mode_set) in_mask <= ctrl_to_inmask(wdata);
    end

    AST_CTRL_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[7]) |=> $stable(in_mask)); // R6
endmodule

// File: rtl/pio_port.sv
// One 8-bit port: an output latch plus the read-back mux that picks pins
// for input bits and the latch for output bits.
module pio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] in_mask,
    input  logic [W-1:0] pins,
    output logic [W-1:0] latch,
    output logic [W-1:0] rdata
);
    // Output latch: cleared by reset or mode-set, loaded by a port write.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch <= '0;
        else if (clr)   latch <= '0;
        else if (wr_en) latch <= wdata;
    end

    // Read-back value per bit.
    assign rdata = (pins & in_mask) | (latch & ~in_mask);

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (latch == $past(wdata))); // R7
endmodule

// File: rtl/memmap_pio.sv
// Top: memory-mapped 24-bit parallel port overlaid on a 4-byte hole in a
// mirrored ROM image. Writes commit on the clock; reads and the ROM
// override are combinational from the bus strobes.
module memmap_pio
    import pio_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hBFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rdata_oe,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              rom_off,
    input  logic [PIO_W-1:0]  pio_in,
    output logic [PIO_W-1:0]  pio_out,
    output logic [PIO_W-1:0]  pio_oe
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + ADDR_W'(3);

    logic                          hit, wr_ctrl, rd_en, mode_set;
    slot_e                         slot;
    logic [NUM_PORTS-1:0]          wr_port;
    logic [PIO_W-1:0]              in_mask;
    logic [NUM_PORTS-1:0][PORT_W-1:0] port_rd;

    pio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .hit(hit), .slot(slot), .wr_port(wr_port), .wr_ctrl(wr_ctrl),
        .rd_en(rd_en)
    );

    pio_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
        .in_mask(in_mask), .mode_set(mode_set)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            pio_port #(.W(PORT_W)) u_port (
                .clk(clk), .rst_n(rst_n),
                .wr_en(wr_port[gp]), .clr(mode_set), .wdata(bus_wdata),
                .in_mask(in_mask[gp*PORT_W +: PORT_W]),
                .pins(pio_in[gp*PORT_W +: PORT_W]),
                .latch(pio_out[gp*PORT_W +: PORT_W]),
                .rdata(port_rd[gp])
            );
        end
    endgenerate

    // Drive the ROM override for the whole window.
    assign rom_off = hit;
    // Output enable is the inverse of the input mask.
    assign pio_oe  = ~in_mask;

    // Read mux: ports drive the bus, the control slot leaves it floating.
    always_comb begin
        bus_rdata_oe = rd_en && (slot != SLOT_CTRL);
        bus_rdata    = '0;
        if (bus_rdata_oe) bus_rdata = port_rd[slot];
    end

    AST_ROM_OFF_NEEDS_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
        rom_off |-> !mreq_n); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (!bus_rdata_oe && !rom_off)); // R2
    AST_RESET_INPUTS: assert property (@(posedge clk)
        !rst_n |=> (pio_oe == '0 && pio_out == '0)); // R3
    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && !wr_n && bus_addr == CTRL_ADDR && bus_wdata[7])
        |=> (pio_out == '0)); // R5
    AST_CTRL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && !rd_n && bus_addr == CTRL_ADDR) |-> !bus_rdata_oe); // R9
endmodule

// File: tb/sim_memmap_pio.sv
module sim_memmap_pio;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic        mreq_n = 1, rd_n = 1, wr_n = 1;
    logic        rom_off;
    logic [23:0] pio_in = '0;
    logic [23:0] pio_out, pio_oe;

    int tests = 0, fails = 0;
    bit done = 0;
    localparam logic [15:0] BASE = 16'd49148;

    always #5 clk = ~clk;

    memmap_pio u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [7:0] d, input bit mem = 1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; mreq_n = !mem; wr_n = 0;
        @(negedge clk);
        mreq_n = 1; wr_n = 1;
    endtask

    task automatic bread(input logic [15:0] a, output logic [7:0] d, output logic oe, input bit mem = 1);
        @(negedge clk);
        bus_addr = a; mreq_n = !mem; rd_n = 0;
        #2;
        d = bus_rdata; oe = bus_rdata_oe;
        mreq_n = 1; rd_n = 1;
    endtask

    function automatic logic [23:0] mask_of(input logic [7:0] c);
        return {{4{c[3]}}, {4{c[0]}}, {8{c[1]}}, {8{c[4]}}};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic        oe;
        logic [23:0] m, lat, pins;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(pio_oe == 0, "R3 oe after reset", pio_oe, 0);
        chk(pio_out == 0, "R3 latches after reset", pio_out, 0);

        // R1: full address sweep with memory request low, then high.
        for (int a = 0; a < 65536; a++) begin
            bus_addr = 16'(a); mreq_n = 0; #1;
            chk(rom_off == (a >= 49148 && a <= 49151), "R1 rom_off decode", rom_off, (a >= 49148 && a <= 49151));
            mreq_n = 1; #1;
            if (a >= 49140 && a <= 49160) chk(rom_off == 0, "R1 rom_off idle", rom_off, 0);
        end

        // R2: I/O-style cycles without memory request are ignored.
        bwrite(BASE + 3, 8'h80, 0);
        @(negedge clk);
        chk(pio_oe == 0, "R2 write without mreq", pio_oe, 0);
        bread(BASE, rd, oe, 0);
        chk(oe == 0, "R2 read without mreq", oe, 0);

        // R4/R7: 128 then 255 to port A.
        bwrite(BASE + 3, 8'd128);
        chk(pio_oe == 24'hFFFFFF, "R4 all outputs", pio_oe, 24'hFFFFFF);
        bwrite(BASE, 8'd255);
        chk(pio_out[7:0] == 8'hFF, "R7 port A all on", pio_out[7:0], 8'hFF);
        bwrite(BASE + 1, 8'h3C);
        bwrite(BASE + 3, 8'h80);
        chk(pio_out == 0, "R5 clear on mode-set", pio_out, 0);

        // Sweep every mode-set byte.
        for (int v = 128; v < 256; v++) begin
            m = mask_of(8'(v));
            bwrite(BASE + 3, 8'(v));
            chk(pio_oe == ~m, "R4 direction mask", pio_oe, ~m);
            chk(pio_out == 0, "R5 latches cleared", pio_out, 0);
            lat  = {8'(v + 3), ~8'(v), 8'(v) ^ 8'h5A};
            pins = {8'(v) ^ 8'hC3, 8'(v), ~8'(v)};
            pio_in = pins;
            bwrite(BASE,     lat[7:0]);
            bwrite(BASE + 1, lat[15:8]);
            bwrite(BASE + 2, lat[23:16]);
            chk(pio_out == lat, "R7 latch load", pio_out, lat);
            for (int p = 0; p < 3; p++) begin
                bread(BASE + 16'(p), rd, oe);
                chk(oe == 1, "R8 port read enable", oe, 1);
                chk(rd == (((pins & m) | (lat & ~m)) >> (8 * p)) % 256, "R8 read mix",
                    rd, (((pins & m) | (lat & ~m)) >> (8 * p)) % 256);
            end
            bread(BASE + 3, rd, oe);
            chk(oe == 0, "R9 control read floats", oe, 0);
            bwrite(BASE + 3, 8'(v) & 8'h7F);
            chk(pio_oe == ~m, "R6 direction kept", pio_oe, ~m);
            chk(pio_out == lat, "R6 latches kept", pio_out, lat);
        end

        // R3 again: reset mid-run.
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk(pio_oe == 0 && pio_out == 0, "R3 reset mid-run", {pio_oe[7:0], pio_out[7:0]}, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule